// File: doc/BRIEF.md
# Memory-Backed Stream Playback Engine

The engine turns a region of external memory into an outgoing sample stream. Software programs a playback base address and a region size in bytes. It then issues a command. A looping command plays the region again and again until a stop command arrives. A counted command plays a given number of 32-bit samples once and then returns to idle. Each 64-bit memory word carries two samples. When the read position reaches the end of the region, it wraps to the region start.

Reads go out as bursts of at most `BURST` words. A burst is shortened wherever the region end or the end of a counted run would otherwise be crossed. A new burst is requested only when the internal word buffer has room for a whole burst. Because of this the response port never needs to stall. A stop prevents any further burst from being requested. The burst already requested is still fully received, and its words drain to the output before the engine goes idle. A play command can ask for a start time. In that case the first word out carries the timestamp on a sideband.

Top module: `replay_play_engine`

## Requirements
- R1: After reset `busy_o`, `mem_req_valid_o` and `out_tvalid_o` are low, and they stay low while the engine is idle.
- R2: The low 12 bits of `cfg_base_i` are ignored, so playback always starts at the 4 KiB-aligned address at or below the programmed base.
- R3: Output words appear in memory order: word i is read from aligned base + 8·(i mod (size/8)), and it is passed unchanged on `out_tdata_o`.
- R4: Every memory request has a length (`mem_req_len_o`, in words) between 1 and `BURST`, and it lies entirely inside [aligned base, aligned base + size). Address and length hold while the request waits for ready.
- R5: Command code 2'b10 (counted) with count N plays exactly ceil(N/2) words and then returns to idle. `out_tlast_o` is high on the final word only.
- R6: Command code 2'b01 (looping) keeps playing until a stop, and `out_tlast_o` never rises during it.
- R7: Command code 2'b11 (stop) during playback blocks any new memory request. Every word of the already-requested burst is still delivered, then `busy_o` falls.
- R8: A play command with `cmd_timed_i` high marks only the first output word with `out_has_time_o`, and that word carries `cmd_time_i` on `out_tuser_o`. Untimed playback never raises `out_has_time_o`.
- R9: `busy_o` rises the cycle after a play command is taken. Play commands (2'b01 or 2'b10) received while busy are ignored. Code 2'b00 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_base_i | input | AW | Playback region base byte address |
| cfg_size_i | input | AW | Playback region size in bytes (multiple of 8) |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 none, 01 loop, 10 counted, 11 stop |
| cmd_count_i | input | CW | Sample count for counted play |
| cmd_timed_i | input | 1 | Tag first output word with a start time |
| cmd_time_i | input | TW | Start timestamp |
| busy_o | output | 1 | Playback active |
| mem_req_valid_o | output | 1 | Read burst request valid |
| mem_req_ready_i | input | 1 | Read burst request accepted |
| mem_req_addr_o | output | AW | Burst byte address |
| mem_req_len_o | output | LW | Burst length in words |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Read data accepted |
| mem_rsp_data_i | input | 64 | Read data word |
| out_tvalid_o | output | 1 | Output word valid |
| out_tready_i | input | 1 | Output word accepted |
| out_tdata_o | output | 64 | Output word (two samples) |
| out_tlast_o | output | 1 | Last word of a counted run |
| out_has_time_o | output | 1 | Word carries a timestamp |
| out_tuser_o | output | TW | Timestamp sideband |

## Verification
The hardest case to reach is a stop that lands while a burst is still outstanding, or while its words are only partly received. To reach it, the bench memory model adds random grant and response delays, and the output side applies random backpressure. A long looping run over a five-word region keeps bursts in flight at every moment, so the stop always meets an outstanding read. The bench then compares the words delivered with the words the memory served. A play command injected in the middle of a counted run, and a misaligned base whose region is shorter than one burst, cover the ignore, alignment and shortening paths.

// File: rtl/replay_play_pkg.sv
package replay_play_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOOP  = 2'b01,
    OP_COUNT = 2'b10,
    OP_STOP  = 2'b11
  } play_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } play_state_e;

  localparam int unsigned WORD_W    = 64;
  localparam int unsigned PAGE_BITS = 12;
endpackage

// File: rtl/replay_word_fifo.sv
module replay_word_fifo #(
  parameter int unsigned W     = 65,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [W-1:0]    din_i,
  input  logic            pop_i,
  output logic [W-1:0]    dout_o,
  output logic            empty_o,
  output logic            full_o,
  output logic [CNTW-1:0] count_o
);
  logic [W-1:0]    mem_q [DEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;
  logic            push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign count_o = cnt_q;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/replay_req_gen.sv
module replay_req_gen
  import replay_play_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 24,
  parameter int unsigned BURST = 4,
  localparam int unsigned LW   = $clog2(BURST + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [AW-1:0] cfg_size_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [CW-1:0] cmd_count_i,
  input  logic          room_i,
  input  logic          drained_i,
  input  logic          rsp_fire_i,
  output logic          busy_o,
  output logic          start_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic [LW-1:0] req_len_o,
  output logic          rsp_last_o
);
  localparam logic [AW-1:0] PAGE_MASK = AW'((1 << PAGE_BITS) - 1);

  play_state_e   state_q;
  logic [AW-1:0] off_q, req_addr_q;
  logic [CW:0]   left_q;
  logic [LW-1:0] req_len_q, rsp_left_q;
  logic          counted_q, req_valid_q, pend_final_q, final_q;

  logic [AW-1:0] base_al, size_w, to_end, len_w, left_ext, off_sum, next_off;
  logic [CW:0]   cnt_p1, words_c;
  logic          play_c, stop_c, issue_c, is_final_c;

  assign base_al  = cfg_base_i & ~PAGE_MASK;
  assign size_w   = cfg_size_i >> 3;
  assign cnt_p1   = {1'b0, cmd_count_i} + 1'b1;
  assign words_c  = cnt_p1 >> 1;
  assign left_ext = {{(AW - CW - 1){1'b0}}, left_q};
  assign to_end   = size_w - off_q;

  always_comb begin
    len_w = AW'(BURST);
    if (to_end < len_w) len_w = to_end;
    if (counted_q && (left_ext < len_w)) len_w = left_ext;
  end

  assign off_sum    = off_q + len_w;
  assign next_off   = (off_sum == size_w) ? '0 : off_sum;
  assign is_final_c = counted_q && (left_ext == len_w);

  assign play_c  = cmd_valid_i && (state_q == ST_IDLE) && (size_w != '0) &&
                   ((cmd_op_i == OP_LOOP) || (cmd_op_i == OP_COUNT));
  assign stop_c  = cmd_valid_i && (cmd_op_i == OP_STOP) && (state_q == ST_RUN);
  assign issue_c = (state_q == ST_RUN) && !stop_c && !req_valid_q &&
                   (rsp_left_q == '0) && room_i && !(counted_q && (left_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      off_q        <= '0;
      left_q       <= '0;
      counted_q    <= 1'b0;
      req_valid_q  <= 1'b0;
      req_addr_q   <= '0;
      req_len_q    <= '0;
      rsp_left_q   <= '0;
      pend_final_q <= 1'b0;
      final_q      <= 1'b0;
    end else begin
      if (req_valid_q && req_ready_i) begin
        req_valid_q <= 1'b0;
        rsp_left_q  <= req_len_q;
        final_q     <= pend_final_q;
      end else if (rsp_fire_i && (rsp_left_q != '0)) begin
        rsp_left_q <= rsp_left_q - 1'b1;
      end

      unique case (state_q)
        ST_IDLE: begin
          if (play_c) begin
            state_q   <= ST_RUN;
            off_q     <= '0;
            counted_q <= (cmd_op_i == OP_COUNT);
            left_q    <= words_c;
            final_q   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (stop_c) begin
            state_q <= ST_DRAIN;
          end else if (counted_q && (left_q == '0)) begin
            state_q <= ST_DRAIN;
          end else if (issue_c) begin
            req_valid_q  <= 1'b1;
            req_addr_q   <= base_al + (off_q << 3);
            req_len_q    <= len_w[LW-1:0];
            off_q        <= next_off;
            pend_final_q <= is_final_c;
            if (counted_q) left_q <= left_q - len_w[CW:0];
            if (is_final_c) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!req_valid_q && (rsp_left_q == '0) && drained_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign start_o     = play_c;
  assign req_valid_o = req_valid_q;
  assign req_addr_o  = req_addr_q;
  assign req_len_o   = req_len_q;
  assign rsp_last_o  = counted_q && final_q && (rsp_left_q == LW'(1));
endmodule

// File: rtl/replay_time_tag.sv
module replay_time_tag #(
  parameter int unsigned TW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          timed_i,
  input  logic [TW-1:0] time_i,
  input  logic          valid_i,
  input  logic          fire_i,
  output logic          has_time_o,
  output logic [TW-1:0] tuser_o
);
  logic          pend_q;
  logic [TW-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ts_q   <= '0;
    end else if (start_i) begin
      pend_q <= timed_i;
      ts_q   <= time_i;
    end else if (fire_i) begin
      pend_q <= 1'b0;
    end
  end

  assign has_time_o = pend_q && valid_i;
  assign tuser_o    = pend_q ? ts_q : '0;
endmodule

// File: rtl/replay_play_engine.sv
module replay_play_engine
  import replay_play_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 24,
  parameter int unsigned TW    = 64,
  parameter int unsigned BURST = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(BURST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     cfg_base_i,
  input  logic [AW-1:0]     cfg_size_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [CW-1:0]     cmd_count_i,
  input  logic              cmd_timed_i,
  input  logic [TW-1:0]     cmd_time_i,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [AW-1:0]     mem_req_addr_o,
  output logic [LW-1:0]     mem_req_len_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  output logic              out_tvalid_o,
  input  logic              out_tready_i,
  output logic [WORD_W-1:0] out_tdata_o,
  output logic              out_tlast_o,
  output logic              out_has_time_o,
  output logic [TW-1:0]     out_tuser_o
);
  localparam int unsigned CNTW     = $clog2(DEPTH + 1);
  localparam int unsigned ROOM_MAX = DEPTH - BURST;

  logic [CNTW-1:0]   fifo_cnt;
  logic              fifo_empty, fifo_full, rsp_fire, out_fire, rsp_last, room, start;
  logic [WORD_W:0]   fifo_dout;

  assign mem_rsp_ready_o = !fifo_full;
  assign rsp_fire        = mem_rsp_valid_i && mem_rsp_ready_o;
  assign out_tvalid_o    = !fifo_empty;
  assign out_fire        = out_tvalid_o && out_tready_i;
  assign room            = (fifo_cnt <= CNTW'(ROOM_MAX));
  assign out_tdata_o     = fifo_dout[WORD_W-1:0];
  assign out_tlast_o     = fifo_dout[WORD_W];

  replay_req_gen #(.AW(AW), .CW(CW), .BURST(BURST)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_base_i (cfg_base_i),
    .cfg_size_i (cfg_size_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_count_i(cmd_count_i),
    .room_i     (room),
    .drained_i  (fifo_empty),
    .rsp_fire_i (rsp_fire),
    .busy_o     (busy_o),
    .start_o    (start),
    .req_valid_o(mem_req_valid_o),
    .req_ready_i(mem_req_ready_i),
    .req_addr_o (mem_req_addr_o),
    .req_len_o  (mem_req_len_o),
    .rsp_last_o (rsp_last)
  );

  replay_word_fifo #(.W(WORD_W + 1), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rsp_fire),
    .din_i  ({rsp_last, mem_rsp_data_i}),
    .pop_i  (out_fire),
    .dout_o (fifo_dout),
    .empty_o(fifo_empty),
    .full_o (fifo_full),
    .count_o(fifo_cnt)
  );

  replay_time_tag #(.TW(TW)) u_tag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .timed_i   (cmd_timed_i),
    .time_i    (cmd_time_i),
    .valid_i   (out_tvalid_o),
    .fire_i    (out_fire),
    .has_time_o(out_has_time_o),
    .tuser_o   (out_tuser_o)
  );
endmodule

// File: rtl/replay_play_checker.sv
module replay_play_checker #(
  parameter int unsigned AW    = 32,
  parameter int unsigned BURST = 4,
  localparam int unsigned LW   = $clog2(BURST + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] cfg_base_i,
  input logic [AW-1:0] cfg_size_i,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_op_i,
  input logic          busy_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [AW-1:0] mem_req_addr_o,
  input logic [LW-1:0] mem_req_len_o,
  input logic          out_tvalid_o,
  input logic          out_tready_i,
  input logic [63:0]   out_tdata_o,
  input logic          out_tlast_o,
  input logic          out_has_time_o
);
  logic [AW:0] reg_lo, reg_hi, req_end;
  assign reg_lo  = {1'b0, cfg_base_i & ~AW'(4095)};
  assign reg_hi  = reg_lo + {1'b0, cfg_size_i & ~AW'(7)};
  assign req_end = {1'b0, mem_req_addr_o} + ((AW + 1)'(mem_req_len_o) << 3);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_valid_o && !out_tvalid_o));

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_len_o)));

  p_burst_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> ((mem_req_len_o != '0) && (mem_req_len_o <= LW'(BURST))));

  p_in_region_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (({1'b0, mem_req_addr_o} >= reg_lo) && (req_end <= reg_hi)));

  p_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_tvalid_o && !out_tready_i) |=>
      (out_tvalid_o && $stable(out_tdata_o) && $stable(out_tlast_o)));

  p_no_req_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == 2'b11) && busy_o && !mem_req_valid_o) |=> !mem_req_valid_o);

  p_time_with_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_has_time_o |-> out_tvalid_o);

  p_busy_from_play_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i && (cmd_op_i == 2'b01 || cmd_op_i == 2'b10)));
endmodule

bind replay_play_engine replay_play_checker #(.AW(AW), .BURST(BURST)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_base_i     (cfg_base_i),
  .cfg_size_i     (cfg_size_i),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_op_i       (cmd_op_i),
  .busy_o         (busy_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_req_len_o  (mem_req_len_o),
  .out_tvalid_o   (out_tvalid_o),
  .out_tready_i   (out_tready_i),
  .out_tdata_o    (out_tdata_o),
  .out_tlast_o    (out_tlast_o),
  .out_has_time_o (out_has_time_o)
);

// File: tb/replay_play_engine_tb_top.sv
module replay_play_engine_tb_top;
  localparam int unsigned AW = 32, CW = 24, TW = 64, BURST = 4, DEPTH = 16;
  localparam int unsigned LW = $clog2(BURST + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] cfg_base = '0, cfg_size = '0;
  logic          cmd_valid = 1'b0, cmd_timed = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [CW-1:0] cmd_count = '0;
  logic [TW-1:0] cmd_time = '0;
  logic          busy, req_valid, req_ready = 1'b0, rsp_valid = 1'b0, rsp_ready;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [63:0]   rsp_data = '0, tdata;
  logic          tvalid, tready = 1'b0, tlast, has_time;
  logic [TW-1:0] tuser;

  replay_play_engine #(.AW(AW), .CW(CW), .TW(TW), .BURST(BURST), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base_i(cfg_base), .cfg_size_i(cfg_size),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_count_i(cmd_count),
    .cmd_timed_i(cmd_timed), .cmd_time_i(cmd_time), .busy_o(busy),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_req_len_o(req_len), .mem_rsp_valid_i(rsp_valid), .mem_rsp_ready_o(rsp_ready),
    .mem_rsp_data_i(rsp_data), .out_tvalid_o(tvalid), .out_tready_i(tready),
    .out_tdata_o(tdata), .out_tlast_o(tlast), .out_has_time_o(has_time), .out_tuser_o(tuser)
  );

  typedef struct packed {
    logic [63:0]   data;
    logic          last;
    logic          tm;
    logic [TW-1:0] ts;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0, n_fail = 0;
  int   out_words = 0, mem_words = 0;
  longint cur_lo = 0, cur_hi = 0;
  bit   run_done = 1'b0;

  function automatic logic [63:0] word_at(logic [31:0] a);
    return {a ^ 32'hC0DE_0000, ~a};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // memory model with random grant and data gaps
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic [AW-1:0] a;
        int l;
        a = req_addr;
        l = int'(req_len);
        chk(l >= 1 && l <= BURST, "R4", "burst length", l, BURST);
        chk(longint'(a) >= cur_lo && longint'(a) + 8 * l <= cur_hi, "R4", "burst region", a, cur_lo);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        for (int i = 0; i < l; i++) begin
          repeat ($urandom_range(0, 1)) @(negedge clk);
          rsp_valid = 1'b1;
          rsp_data  = word_at(a + AW'(8 * i));
          while (!rsp_ready) @(negedge clk);
          @(negedge clk);
          mem_words++;
          rsp_valid = 1'b0;
        end
      end
    end
  end

  // output monitor: owns tready, compares accepted beats against the scoreboard
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      tready = ($urandom_range(0, 3) != 0);
      if (tvalid && tready) begin
        out_words++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected word", tdata, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(tdata == e.data, "R3", "data", tdata, e.data);
          chk(tlast == e.last, "R5", "last flag", tlast, e.last);
          chk(has_time == e.tm, "R8", "time flag", has_time, e.tm);
          if (e.tm) chk(tuser == e.ts, "R8", "timestamp", tuser, e.ts);
        end
      end
    end
  end

  task automatic send_cmd(logic [1:0] op, int cnt, bit timed, logic [TW-1:0] t);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_count = CW'(cnt); cmd_timed = timed; cmd_time = t;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_timed = 1'b0;
  endtask

  task automatic set_region(logic [AW-1:0] base, logic [AW-1:0] size);
    cfg_base = base;
    cfg_size = size;
    cur_lo   = longint'(base & ~AW'(4095));
    cur_hi   = cur_lo + longint'(size);
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, req, "return to idle", busy, 0);
  endtask

  task automatic push_words(int words, bit counted, bit timed, logic [TW-1:0] t);
    longint sw = (cur_hi - cur_lo) / 8;
    for (int i = 0; i < words; i++) begin
      exp_t e;
      e.data = word_at(32'(cur_lo + 8 * (i % sw)));
      e.last = counted && (i == words - 1);
      e.tm   = timed && (i == 0);
      e.ts   = t;
      exp_q.push_back(e);
    end
  endtask

  task automatic play_counted(logic [AW-1:0] base, logic [AW-1:0] size, int cnt,
                              bit timed, logic [TW-1:0] t, bit inject);
    int words = (cnt + 1) / 2;
    int o0;
    set_region(base, size);
    push_words(words, 1'b1, timed, t);
    o0 = out_words;
    send_cmd(2'b10, cnt, timed, t);
    chk(busy, "R9", "busy after play", busy, 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      send_cmd(2'b10, 500, 1'b0, '0);  // R9: ignored while busy
      send_cmd(2'b01, 0, 1'b1, 64'hDEAD);
      send_cmd(2'b00, 0, 1'b0, '0);
    end
    wait_idle("R5");
    chk(out_words - o0 == words, "R5", "word count", out_words - o0, words);
    chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    int o0, m0;
    repeat (3) @(negedge clk);
    chk(!busy && !tvalid && !req_valid, "R1", "reset outputs", {busy, tvalid, req_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !tvalid && !req_valid, "R1", "idle after reset", {busy, tvalid, req_valid}, 0);

    // R3 R5: counted run over a 10-word region with wrap
    play_counted(32'h0000_1000, 32'd80, 30, 1'b0, '0, 1'b0);
    // R2 R4 R8: misaligned base, 3-word region shorter than a burst, odd count, timed
    play_counted(32'h0000_5123, 32'd24, 7, 1'b1, 64'h0012_3456_789A_BCDE, 1'b0);
    // R9: play commands during a counted run are ignored
    play_counted(32'h0000_2000, 32'd64, 40, 1'b0, '0, 1'b1);

    // R6 R7: looping run stopped with bursts in flight
    set_region(32'h0000_8000, 32'd40);
    push_words(400, 1'b0, 1'b1, 64'hABCD_0001);
    o0 = out_words; m0 = mem_words;
    send_cmd(2'b01, 0, 1'b1, 64'hABCD_0001);
    repeat (120) @(negedge clk);
    chk(busy, "R6", "still looping before stop", busy, 1);
    chk(out_words - o0 > 10, "R6", "loop passed region end", out_words - o0, 11);
    send_cmd(2'b11, 0, 1'b0, '0);
    wait_idle("R7");
    repeat (4) @(negedge clk);
    chk(out_words - o0 == mem_words - m0, "R7", "served words all delivered",
        out_words - o0, mem_words - m0);
    chk(!req_valid && !tvalid, "R1", "quiet after stop", {req_valid, tvalid}, 0);
    exp_q.delete();

    // R5: single-word counted run after a stop
    play_counted(32'h0000_3000, 32'd16, 2, 1'b0, '0, 1'b0);
    run_done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!run_done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!run_done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual=%0d expected<150000", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule